// File: doc/BRIEF.md
# Token-Driven Two-Way Stream Select

This block is a streaming select actor. It has one control stream that carries one bit, two 8-bit data streams (a "true" stream and a "false" stream) and one 8-bit result stream. Each stream uses a valid/ready handshake. A token moves on a rising clock edge when both valid and ready are high. The actor works in sequence. First it takes one control token. Then it takes exactly one token from the data stream that the control bit named, and it places that token on the result stream. A plain multiplexer would look at both data streams at once. This actor leaves the unselected data stream untouched, so that stream keeps its pending token for a later round.

Each state of the actor has an input signature, the set of inputs it reads. A state fires only when every input in its signature holds a token. Firing consumes those tokens and performs the state's action in one clock edge, and at most one firing happens per cycle. Writes to the result stream do not block. They go through a one-entry output register. A data state can fire only when that register is empty, or when the consumer is draining it in the same cycle.

Top module: `sel_actor`

## Requirements
- R1: While rst_n is low, and after it is released, out_valid is 0 and the actor waits for a control token. In that state ctl_ready is 1 and tdat_ready and fdat_ready are both 0. Reset is asynchronous and clears out_valid at once.
- R2: In the control state, only ctl_ready is asserted. A control token is consumed on a rising edge where ctl_valid and ctl_ready are both 1.
- R3: After the actor consumes a control token of value 1, it reads only the true stream (tdat_ready may be 1, fdat_ready is 0). After a control token of value 0, it reads only the false stream (fdat_ready may be 1, tdat_ready is 0). ctl_ready is 0 in both data states.
- R4: A data token consumed at edge k appears on out_data with out_valid at 1 after edge k. The actor is back in the control state after edge k (ctl_ready is 1).
- R5: A token on a stream outside the current signature is never consumed. A token left pending on the unselected data stream is still there, unchanged, when a later control token selects that stream.
- R6: While the current state's signature input has no token, the actor does not fire and stays in that state for any number of cycles. No other input is taken in the meantime.
- R7: While out_valid is 1 and out_ready is 0, out_data and out_valid hold their values and both data readies are 0. No data firing overwrites the held token.
- R8: When the output register is full and out_ready is 1 in the same cycle as a data state has its token, the actor fires in that cycle. The old token leaves, and the new token is on out_data after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_valid | input | 1 | A control token is present |
| ctl_data | input | 1 | Control value: 1 selects the true stream, 0 selects the false stream |
| ctl_ready | output | 1 | The actor takes the control token |
| tdat_valid | input | 1 | A true-stream token is present |
| tdat_data | input | DATA_W (8) | True-stream data |
| tdat_ready | output | 1 | The actor takes the true-stream token |
| fdat_valid | input | 1 | A false-stream token is present |
| fdat_data | input | DATA_W (8) | False-stream data |
| fdat_ready | output | 1 | The actor takes the false-stream token |
| out_valid | output | 1 | The output register holds a token |
| out_data | output | DATA_W (8) | Output token |
| out_ready | input | 1 | The consumer takes the output token |

## Verification
Two functions can fall in the same cycle: the consumer draining the output register, and a data state loading a new token into that register. The bench provokes this case on purpose. It holds out_ready low so that one result stays parked while a second control token routes the actor into a data state whose token is already waiting. It then raises out_ready. In that cycle the bench expects the data ready to rise. It also expects the parked value to leave first and the new value to follow on the very next cycle, with nothing lost and nothing duplicated.

// File: rtl/sel_pkg.sv
package sel_pkg;
  typedef enum logic [1:0] {
    ST_CTL   = 2'd0,
    ST_TRUE  = 2'd1,
    ST_FALSE = 2'd2
  } sel_state_e;
endpackage

// File: rtl/sel_fire_ctrl.sv
module sel_fire_ctrl
  import sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_valid,
  input  logic ctl_bit,
  input  logic tdat_valid,
  input  logic fdat_valid,
  input  logic slot_free,
  output logic ctl_ready,
  output logic tdat_ready,
  output logic fdat_ready,
  output logic load_en,
  output logic load_true
);
  sel_state_e state_q, state_d;
  logic ctl_fire, t_fire, f_fire;

  always_comb begin
    ctl_ready  = (state_q == ST_CTL);
    tdat_ready = (state_q == ST_TRUE)  && slot_free;
    fdat_ready = (state_q == ST_FALSE) && slot_free;
    ctl_fire   = ctl_ready  && ctl_valid;
    t_fire     = tdat_ready && tdat_valid;
    f_fire     = fdat_ready && fdat_valid;
    state_d    = state_q;
    unique case (state_q)
      ST_CTL:   if (ctl_fire) state_d = ctl_bit ? ST_TRUE : ST_FALSE;
      ST_TRUE:  if (t_fire)   state_d = ST_CTL;
      ST_FALSE: if (f_fire)   state_d = ST_CTL;
      default:                state_d = ST_CTL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CTL;
    else        state_q <= state_d;
  end

  assign load_en   = t_fire || f_fire;
  assign load_true = (state_q == ST_TRUE);

  // R3: a consumed control bit routes to exactly one data stream
  p_ctl_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_fire |=> !ctl_ready && ($past(ctl_bit) ? !fdat_ready : !tdat_ready));

  // R4: a data firing returns to the control state
  p_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (t_fire || f_fire) |=> ctl_ready);
endmodule

// File: rtl/sel_out_slot.sv
module sel_out_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              slot_free
);
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q;

  always_comb begin
    slot_free = !vld_q || out_ready;
    vld_d     = vld_q;
    if (load_en)        vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) dat_q <= load_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  // R4: a loaded token is presented on the next cycle
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> out_valid && (out_data == $past(load_data)));

  // R7: a stalled token is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
endmodule

// File: rtl/sel_actor.sv
module sel_actor #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  input  logic              ctl_data,
  output logic              ctl_ready,
  input  logic              tdat_valid,
  input  logic [DATA_W-1:0] tdat_data,
  output logic              tdat_ready,
  input  logic              fdat_valid,
  input  logic [DATA_W-1:0] fdat_data,
  output logic              fdat_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  logic              slot_free;
  logic              load_en;
  logic              load_true;
  logic [DATA_W-1:0] pick_data;

  sel_fire_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_valid  (ctl_valid),
    .ctl_bit    (ctl_data),
    .tdat_valid (tdat_valid),
    .fdat_valid (fdat_valid),
    .slot_free  (slot_free),
    .ctl_ready  (ctl_ready),
    .tdat_ready (tdat_ready),
    .fdat_ready (fdat_ready),
    .load_en    (load_en),
    .load_true  (load_true)
  );

  assign pick_data = load_true ? tdat_data : fdat_data;

  sel_out_slot #(.DATA_W(DATA_W)) i_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_data (pick_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .slot_free (slot_free)
  );

  // R7: a full, stalled output register blocks both data readies
  p_no_clobber_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (!tdat_ready && !fdat_ready));

  // R6: a waiting data state keeps waiting while its token is absent
  p_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tdat_ready && !tdat_valid) |=> tdat_ready);
endmodule

// File: tb/test_sel_actor.sv
module test_sel_actor;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {ctl bit, true value, false value}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'hA1, 8'h0F}, {1'b0, 8'h22, 8'hB3}, {1'b1, 8'hFF, 8'h00},
    {1'b1, 8'h00, 8'hFF}, {1'b0, 8'h5C, 8'hC5}, {1'b0, 8'h81, 8'h18},
    {1'b1, 8'h7E, 8'hE7}, {1'b0, 8'h01, 8'h80}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_valid, ctl_data, ctl_ready;
  logic tdat_valid, tdat_ready, fdat_valid, fdat_ready;
  logic [7:0] tdat_data, fdat_data, out_data;
  logic out_valid, out_ready;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_mem [0:63];
  int wr_ptr = 0;
  int rd_ptr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sel_actor i_sel_actor (
    .clk(clk), .rst_n(rst_n),
    .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ctl_ready(ctl_ready),
    .tdat_valid(tdat_valid), .tdat_data(tdat_data), .tdat_ready(tdat_ready),
    .fdat_valid(fdat_valid), .fdat_data(fdat_data), .fdat_ready(fdat_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v);
    exp_mem[wr_ptr[5:0]] = v;
    wr_ptr++;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // output monitor: a token leaves when valid and ready meet at an edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (rd_ptr >= wr_ptr) check(1'b0, "R4 unexpected output", out_data, 0);
      else begin
        check(out_data == exp_mem[rd_ptr[5:0]], "R4 output order/value",
              out_data, exp_mem[rd_ptr[5:0]]);
        rd_ptr++;
      end
    end
  end

  // one round: control token then one token on the selected stream only
  task automatic send_one(input logic c, input logic [7:0] v);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_data = c;
    if (c) begin tdat_valid = 1'b1; tdat_data = v; end
    else   begin fdat_valid = 1'b1; fdat_data = v; end
    push(v);
    @(negedge clk);
    ctl_valid = 1'b0;
    #1;
    if (c) check(tdat_ready && !fdat_ready, "R3 true route", {tdat_ready, fdat_ready}, 2);
    else   check(fdat_ready && !tdat_ready, "R3 false route", {tdat_ready, fdat_ready}, 1);
    @(negedge clk);
    if (c) tdat_valid = 1'b0; else fdat_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_valid = 1'b0; ctl_data = 1'b0;
    tdat_valid = 1'b0; tdat_data = '0; fdat_valid = 1'b0; fdat_data = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(ctl_ready && !tdat_ready && !fdat_ready, "R1 readies after reset",
          {ctl_ready, tdat_ready, fdat_ready}, 4);

    // table walk: both data streams offered every time
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      ctl_valid = 1'b1; ctl_data = VEC[i][16];
      tdat_valid = 1'b1; tdat_data = VEC[i][15:8];
      fdat_valid = 1'b1; fdat_data = VEC[i][7:0];
      #1;
      check(ctl_ready && !tdat_ready && !fdat_ready, "R2 only control ready",
            {ctl_ready, tdat_ready, fdat_ready}, 4);
      @(negedge clk);
      ctl_valid = 1'b0;
      #1;
      if (VEC[i][16]) begin
        check(tdat_ready && !fdat_ready && !ctl_ready, "R3 true route",
              {ctl_ready, tdat_ready, fdat_ready}, 2);
        push(VEC[i][15:8]);
      end else begin
        check(fdat_ready && !tdat_ready && !ctl_ready, "R3 false route",
              {ctl_ready, tdat_ready, fdat_ready}, 1);
        push(VEC[i][7:0]);
      end
      @(negedge clk);
      tdat_valid = 1'b0; fdat_valid = 1'b0;
      #1;
      check(ctl_ready, "R4 back to control", ctl_ready, 1);
    end

    // R5: pending false token survives two true rounds
    @(negedge clk);
    fdat_valid = 1'b1; fdat_data = 8'h77;
    send_one(1'b1, 8'h01);
    send_one(1'b1, 8'h02);
    #1;
    check(fdat_valid && fdat_data == 8'h77, "R5 bench token intact", fdat_data, 8'h77);
    send_one(1'b0, 8'h77);

    // R6: data state waits without its token; control token not taken
    @(negedge clk);
    ctl_valid = 1'b1; ctl_data = 1'b1;
    @(negedge clk);
    ctl_data = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      check(!ctl_ready && tdat_ready && !out_valid, "R6 blocked read holds",
            {ctl_ready, tdat_ready, out_valid}, 2);
      @(negedge clk);
    end
    tdat_valid = 1'b1; tdat_data = 8'h5A; push(8'h5A);
    @(negedge clk);
    tdat_valid = 1'b0;
    @(negedge clk);
    ctl_valid = 1'b0;
    fdat_valid = 1'b1; fdat_data = 8'h11; push(8'h11);
    @(negedge clk);
    fdat_valid = 1'b0;

    // R7/R8: stall, then drain and fire in the same cycle
    @(negedge clk);
    out_ready = 1'b0;
    ctl_valid = 1'b1; ctl_data = 1'b1; tdat_valid = 1'b1; tdat_data = 8'hA5;
    @(negedge clk);
    ctl_valid = 1'b0; push(8'hA5);
    @(negedge clk);
    tdat_valid = 1'b0;
    ctl_valid = 1'b1; ctl_data = 1'b0; fdat_valid = 1'b1; fdat_data = 8'h3C;
    #1;
    check(out_valid && out_data == 8'hA5, "R4 stalled output value", out_data, 8'hA5);
    @(negedge clk);
    ctl_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(!fdat_ready, "R7 no fire while stalled", fdat_ready, 0);
      check(out_valid && out_data == 8'hA5, "R7 held output", out_data, 8'hA5);
      @(negedge clk);
    end
    out_ready = 1'b1; push(8'h3C);
    #1;
    check(fdat_ready, "R8 fire while draining", fdat_ready, 1);
    @(negedge clk);
    fdat_valid = 1'b0;
    #1;
    check(out_valid && out_data == 8'h3C, "R8 new token follows", out_data, 8'h3C);

    // R1: asynchronous reset clears a parked token
    @(negedge clk);
    out_ready = 1'b0;
    ctl_valid = 1'b1; ctl_data = 1'b1; tdat_valid = 1'b1; tdat_data = 8'hEE;
    @(negedge clk);
    ctl_valid = 1'b0;
    @(negedge clk);
    tdat_valid = 1'b0;
    #1;
    check(out_valid, "R1 token parked before reset", out_valid, 1);
    #1;
    rst_n = 1'b0;
    #1;
    check(!out_valid && ctl_ready, "R1 async reset clears", {out_valid, ctl_ready}, 1);
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(rd_ptr == wr_ptr, "R4 all expected tokens seen", rd_ptr, wr_ptr);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule